// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single line that rests high. A frame is made of a low start bit, five to eight payload bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The payload length, the parity kind and the stop count are chosen per frame through input pins. An internal divider sets the bit period in clock cycles from a programmable divisor.

A client presents a word and its settings, then raises `start` for one cycle while `busy` is low. The block copies the word, the settings and the divisor on that edge, raises `busy` and drives the frame. Changes on the inputs during the frame have no effect. The frame follows five named states. IDLE goes to START when a strobe is accepted. START goes to DATA after one bit period. DATA loops on itself until the last active payload bit has been held for its period. It then goes to PARITY when parity is enabled, and to STOP when it is not. PARITY goes to STOP after one period. STOP goes back to IDLE after the first stop period when one stop bit is chosen, and after the second stop period when two are chosen.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is active, `tx_line` is 1 and `busy` is 0.
- R2: Each frame opens with exactly one bit period of `tx_line` = 0.
- R3: The payload is sent least significant bit first. Its length is set by `data_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `data_in` above that length are neither sent nor used in parity.
- R4: `par_mode` 1 selects even parity, where the parity bit is the XOR of the active payload bits. `par_mode` 2 selects odd parity, the inverse of that XOR. `par_mode` 0 or 3 leaves the parity slot out of the frame. For 0x29 with 8 bits and even parity, the parity bit is 1.
- R5: When parity is present, the parity bit follows the last payload bit directly and comes before the first stop bit.
- R6: A frame ends with stop bits at 1: one when `stop_two` is 0, two when `stop_two` is 1.
- R7: Every bit of a frame is held for exactly P clock cycles, where P = `baud_div`, and P = 1 when `baud_div` is 0.
- R8: A `start` strobe that arrives while `busy` is 1 is ignored.
- R9: Data, length, parity mode, stop count and divisor are captured on the edge that accepts the strobe. Changes to them later have no effect on the frame in flight.
- R10: `busy` goes high in the cycle after the accepting edge. It stays high for exactly (1 + length + parity bits + stop bits) × P cycles and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Clock cycles per bit; 0 is treated as 1 |
| data_in | input | DATA_W | Word to send |
| data_len | input | LEN_W | Payload length code (length = 5 + code) |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| stop_two | input | 1 | 1 selects two stop bits |
| start | input | 1 | Send request, taken only while not busy |
| tx_line | output | 1 | Serial output, high at rest |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bound checker watches the rules that hold in every cycle. The line is high whenever the block is idle. A rising `busy` always comes with a low line. The line and `busy` cannot change between two baud ticks. An accepted strobe raises `busy` on the next edge, and the last bit before `busy` falls is high. The bench sweeps every length, parity mode and stop count over several words and divisors, including a divisor of zero. Only these sweeps can show bit order, the parity value, the omission of the parity slot, the exact frame length, and that strobes and setting changes made in mid-frame are ignored.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_EVEN = 2'd1,
        PM_ODD  = 2'd2,
        PM_RSVD = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/sft_baud_gen.sv
module sft_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // a divisor is taken while cleared; zero is promoted to one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
            cnt_q <= '0;
        end else if (clear) begin
            div_q <= (divisor == '0) ? DIV_W'(1) : divisor;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = (cnt_q == div_q - DIV_W'(1));

endmodule

// File: rtl/sft_parity.sv
module sft_parity #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len_code,
    output logic              par_even
);

    logic [DATA_W-1:0] active_mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < MIN_LEN) begin : g_fixed
            assign active_mask[i] = 1'b1;
        end else begin : g_sel
            assign active_mask[i] = (int'(len_code) + MIN_LEN) > i;
        end
    end

    assign par_even = ^(data & active_mask);

endmodule

// File: rtl/sft_frame_fsm.sv
module sft_frame_fsm
    import sft_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [1:0]        par_mode,
    input  logic              stop_two,
    input  logic              par_even,
    output logic              tx_line,
    output logic              busy
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_q;
    logic              par_q;
    logic              par_en_q;
    logic              two_q;
    logic              stop_idx_q;
    logic              accept;

    assign accept = start && (state_q == ST_IDLE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_START;
            ST_START:  if (tick) state_d = ST_DATA;
            ST_DATA:   if (tick && (cnt_q == last_q))
                           state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (tick) state_d = ST_STOP;
            ST_STOP:   if (tick && (stop_idx_q == two_q)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            cnt_q      <= '0;
            last_q     <= '0;
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            two_q      <= 1'b0;
            stop_idx_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                shreg_q    <= data_in;
                cnt_q      <= '0;
                last_q     <= CNT_W'(MIN_LEN - 1) + CNT_W'(len_code);
                par_q      <= par_even ^ (par_mode == PM_ODD);
                par_en_q   <= (par_mode == PM_EVEN) || (par_mode == PM_ODD);
                two_q      <= stop_two;
                stop_idx_q <= 1'b0;
            end else if (tick) begin
                if ((state_q == ST_DATA) && (cnt_q != last_q)) begin
                    shreg_q <= shreg_q >> 1;
                    cnt_q   <= cnt_q + CNT_W'(1);
                end
                if (state_q == ST_STOP) begin
                    stop_idx_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   tx_line = 1'b1;
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shreg_q[0];
            ST_PARITY: tx_line = par_q;
            ST_STOP:   tx_line = 1'b1;
            default:   tx_line = 1'b1;
        endcase
        busy = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int DIV_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  data_len,
    input  logic [1:0]        par_mode,
    input  logic              stop_two,
    input  logic              start,
    output logic              tx_line,
    output logic              busy
);

    logic baud_tick;
    logic par_even;

    sft_baud_gen #(
        .DIV_W (DIV_W)
    ) i_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!busy),
        .divisor (baud_div),
        .tick    (baud_tick)
    );

    sft_parity #(
        .DATA_W  (DATA_W),
        .MIN_LEN (MIN_LEN),
        .LEN_W   (LEN_W)
    ) i_parity (
        .data     (data_in),
        .len_code (data_len),
        .par_even (par_even)
    );

    sft_frame_fsm #(
        .DATA_W  (DATA_W),
        .MIN_LEN (MIN_LEN),
        .LEN_W   (LEN_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (baud_tick),
        .data_in  (data_in),
        .len_code (data_len),
        .par_mode (par_mode),
        .stop_two (stop_two),
        .par_even (par_even),
        .tx_line  (tx_line),
        .busy     (busy)
    );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic tx_line,
    input logic tick
);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);                                       // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);                                // R2

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx_line));                    // R7

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);                                // R10

    AST_ACCEPT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                               // R10

    AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_line));                          // R6

endmodule

bind serial_frame_tx sft_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .tx_line (tx_line),
    .tick    (baud_tick)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic [7:0]  data_in = 8'd0;
    logic [1:0]  data_len = 2'd0;
    logic [1:0]  par_mode = 2'd0;
    logic        stop_two = 1'b0;
    logic        start = 1'b0;
    logic        tx_line;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .baud_div (baud_div),
        .data_in  (data_in),
        .data_len (data_len),
        .par_mode (par_mode),
        .stop_two (stop_two),
        .start    (start),
        .tx_line  (tx_line),
        .busy     (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected line level for each bit slot; returns the slot count
    function automatic int build_frame(input logic [7:0] d, input int len, input int mode,
                                       input bit two, output logic [11:0] bits);
        int n = 0;
        logic p = 1'b0;
        bits = '1;
        bits[n++] = 1'b0;
        for (int i = 0; i < len; i++) begin
            bits[n++] = d[i];
            p ^= d[i];
        end
        if (mode == 1) bits[n++] = p;
        if (mode == 2) bits[n++] = ~p;
        bits[n++] = 1'b1;
        if (two) bits[n++] = 1'b1;
        return n;
    endfunction

    function automatic string slot_tag(input int k, input int len, input int mode);
        if (k == 0) return "R2";
        if (k <= len) return "R3";
        if ((mode == 1 || mode == 2) && k == len + 1) return "R4 R5";
        return "R6";
    endfunction

    task automatic run_frame(input logic [7:0] d, input int len, input int mode,
                             input bit two, input int div, input bit disturb,
                             output logic [11:0] got);
        logic [11:0] exp_bits;
        int nb, per, bad_j, bad_act, bad_exp;
        bit bad_busy;
        nb = build_frame(d, len, mode, two, exp_bits);
        per = (div == 0) ? 1 : div;
        got = '1;
        bad_j = -1;
        bad_act = 0;
        bad_exp = 0;
        bad_busy = 1'b0;
        @(negedge clk);
        data_in  = d;
        data_len = 2'(len - 5);
        par_mode = 2'(mode);
        stop_two = two;
        baud_div = 16'(div);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
        for (int j = 0; j < nb * per; j++) begin
            if (j > 0) @(negedge clk);
            if (j % per == 0) got[j / per] = tx_line;
            if (bad_j < 0 && (tx_line !== exp_bits[j / per] || busy !== 1'b1)) begin
                bad_j    = j;
                bad_busy = (busy !== 1'b1);
                bad_act  = bad_busy ? int'(busy) : int'(tx_line);
                bad_exp  = bad_busy ? 1 : int'(exp_bits[j / per]);
            end
            if (disturb && j == 0) begin
                // R8 R9: new strobe and new settings in mid-frame
                data_in  = ~d;
                data_len = 2'(len - 4);
                par_mode = 2'(mode + 1);
                stop_two = ~two;
                baud_div = 16'(per + 2);
                start    = 1'b1;
            end
            if (disturb && j == 1) start = 1'b0;
        end
        if (bad_j >= 0)
            check(1'b0, bad_busy ? "R10 busy in frame"
                                 : $sformatf("%s R7 R8 R9 slot %0d len %0d mode %0d stop2 %0d div %0d",
                                             slot_tag(bad_j / per, len, mode), bad_j / per,
                                             len, mode, two, div),
                  bad_act, bad_exp);
        else
            check(1'b1, "R3 frame", 0, 0);
        start = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && tx_line === 1'b1, "R10 R1 end of frame",
              int'({busy, tx_line}), 1);
    endtask

    initial begin
        logic [11:0] got;
        logic [7:0] words [4];
        int divs [3];
        words[0] = 8'h29; words[1] = 8'hD6; words[2] = 8'hE0; words[3] = 8'h1F;
        divs[0] = 0; divs[1] = 1; divs[2] = 3;
        repeat (3) @(negedge clk);
        check(tx_line === 1'b1 && busy === 1'b0, "R1 in reset", int'({busy, tx_line}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b1 && busy === 1'b0, "R1 after reset", int'({busy, tx_line}), 1);

        // R4: known parity value, 0x29, 8 bits, even
        run_frame(8'h29, 8, 1, 1'b0, 2, 1'b0, got);
        check(got[9] === 1'b1, "R4 parity of 0x29", int'(got[9]), 1);
        // R4: odd parity over 5 active bits only; upper bits set to 1
        run_frame(8'hE9, 5, 2, 1'b0, 1, 1'b0, got);
        check(got[6] === 1'b1, "R4 odd parity masked", int'(got[6]), 1);

        // sweep all lengths, parity modes, stop counts, words and divisors
        for (int w = 0; w < 4; w++)
            for (int l = 5; l <= 8; l++)
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 2; s++)
                        for (int v = 0; v < 3; v++)
                            run_frame(words[w], l, m, s[0], divs[v], ((l + m + s + v) % 2) == 1, got);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule